// File: doc/BRIEF.md
# Challenge-Response Debug Unlock

This block guards the debug port of a chip behind a challenge-response exchange. A debugger first issues a request; the block answers by loading the chip's 64-bit unique identifier into a 130-bit shift register, whose low bit is presented on the serial output. While that challenge is shifted out, the debugger shifts in a 130-bit answer word. The answer carries a 128-bit response in its upper bits and a 2-bit selector in its two lowest bits.

A submit command then compares the 128-bit response against one of two fused 128-bit secrets. The selector picks which secret is used: one unlocks normal-world debug, the other unlocks secure-world debug. A match sets the matching debug enable and pulses a pass flag. Any other outcome pulses a fail flag. The enables stay set until reset. Three failures in a row lock the block until the next reset.

A password server outside the block maps the identifier to the right secret. The TAP controller and the fuse reader are also outside the block and feed its ports.

Top module: `dbg_challenge_unlock`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output goes low: `tdo_o`, `pass_o`, `fail_o`, `locked_o`, `nw_dbg_en_o` and `tz_dbg_en_o`. No challenge is pending and the failure count is zero.
- R2: A request loads the unique ID into bits 63:0 of the shift register and zeros into bits 129:64. `tdo_o` always shows bit 0 of the register, so the ID leaves LSB first, followed by zeros.
- R3: Each shift cycle moves the register one place toward bit 0 and places `tdi_i` in bit 129. After 130 shifts, the first bit shifted in sits at bit 0. Bits 1:0 of the register are the selector and bits 129:2 are the response.
- R4: Selector 2'b01 with `nw_fuse_ok_i` high compares the response with `nw_secret_i`. On a match, `pass_o` is high for the one cycle after the submit edge, and `nw_dbg_en_o` is set from that same edge.
- R5: Selector 2'b10 compares the response with `tz_secret_i`, but only when `tz_fuse_ok_i` is high. A match sets both `tz_dbg_en_o` and `nw_dbg_en_o` and pulses `pass_o`.
- R6: A submit fails and pulses `fail_o` in any of these cases: the selector is 2'b00 or 2'b11, the selected secret's fuse-valid flag is low, or the response differs from the selected secret.
- R7: A submit with no challenge pending fails. Every submit consumes the pending challenge, so a second submit needs a new request.
- R8: Each failed submit adds one to a failure count, and a pass clears it. When the count reaches 3, `locked_o` goes high. From then until reset, every submit fails without a comparison and grants nothing.
- R9: Once set, a debug enable stays high until reset, whatever later submits do.
- R10: Each submit gives exactly one of `pass_o` or `fail_o`, for exactly one cycle. Neither flag rises without a submit.
- R11: All 128 response bits take part in the comparison, in a fixed single cycle. A response that differs in only bit 0 or only bit 127 fails.
- R12: If `submit_i` is high, `req_i` and `shift_i` are ignored in that cycle. If `req_i` is high, `shift_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Debug request: loads the challenge |
| submit_i | input | 1 | Submit the shifted answer for checking |
| shift_i | input | 1 | Shift the register one bit |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (register bit 0) |
| uid_i | input | 64 | Fused chip unique ID |
| nw_secret_i | input | 128 | Fused normal-world secret |
| tz_secret_i | input | 128 | Fused secure-world secret |
| nw_fuse_ok_i | input | 1 | Normal-world secret fuses valid |
| tz_fuse_ok_i | input | 1 | Secure-world secret fuses valid |
| pass_o | output | 1 | One-cycle pass pulse |
| fail_o | output | 1 | One-cycle fail pulse |
| locked_o | output | 1 | Failure limit reached |
| nw_dbg_en_o | output | 1 | Normal-world debug enable |
| tz_dbg_en_o | output | 1 | Secure-world debug enable |

## Verification
The assertions assume that the fused ID, secrets and valid flags are static while out of reset, like real fuses. They also assume the command strobes are single-cycle pulses. The stimulus sets the fuse values only while reset is asserted and pulses each command for one cycle. It keeps the strobes apart except in one deliberate overlap, which checks the priority in R12 at the ports.

// File: rtl/dbgu_pkg.sv
// Package dbgu_pkg: shared sizes and selector codes for the debug unlock block.
// Assumes the secret width is a multiple of the compare lane width.
package dbgu_pkg;
    localparam int ID_W     = 64;
    localparam int SECRET_W = 128;
    localparam int SEL_W    = 2;
    localparam int WORD_W   = SECRET_W + SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 2'b00,
        SEL_NW   = 2'b01,
        SEL_TZ   = 2'b10,
        SEL_BAD  = 2'b11
    } sel_e;
endpackage

// File: rtl/dbgu_capture.sv
// Module dbgu_capture: a single shift register that carries the challenge out
// and the answer word in. A load places the ID in the low bits and clears the
// rest. A shift moves toward bit 0 and inserts the serial input at the top.
// Assumes load takes priority over shift; the caller masks shift on load.
module dbgu_capture #(
    parameter int WORD_W = 130,
    parameter int ID_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              tdi_i,
    input  logic [ID_W-1:0]   uid_i,
    output logic [WORD_W-1:0] word_o,
    output logic              tdo_o
);
    localparam int PAD_W = WORD_W - ID_W;

    logic [WORD_W-1:0] sreg_q;

    // Load the challenge or shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= {{PAD_W{1'b0}}, uid_i};
        end else if (shift_i) begin
            sreg_q <= {tdi_i, sreg_q[WORD_W-1:1]};
        end
    end

    assign word_o = sreg_q;
    assign tdo_o  = sreg_q[0];

    AST_LOAD_SHOWS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tdo_o == $past(uid_i[0])));                  // R2
    AST_SHIFT_TAKES_TDI: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (word_o[WORD_W-1] == $past(tdi_i)));  // R3
endmodule

// File: rtl/dbgu_compare.sv
// Module dbgu_compare: chooses a fused secret from the selector and compares
// all of its bits with the response, lane by lane. There is no early exit, so
// the result always takes the same single cycle. Grants only a valid selector
// whose fuse-valid flag is set. Assumes SECRET_W is a multiple of LANE_W.
module dbgu_compare
    import dbgu_pkg::*;
#(
    parameter int SECRET_W = 128,
    parameter int LANE_W   = 32
) (
    input  logic [SECRET_W+SEL_W-1:0] word_i,
    input  logic [SECRET_W-1:0]       nw_secret_i,
    input  logic [SECRET_W-1:0]       tz_secret_i,
    input  logic                      nw_fuse_ok_i,
    input  logic                      tz_fuse_ok_i,
    output logic                      grant_nw_o,
    output logic                      grant_tz_o
);
    localparam int LANES = SECRET_W / LANE_W;

    sel_e                sel;
    logic [SECRET_W-1:0] resp;
    logic [SECRET_W-1:0] ref_secret;
    logic [LANES-1:0]    lane_diff;
    logic                equal;

    // Split the word and pick the secret to compare with.
    always_comb begin
        sel        = sel_e'(word_i[SEL_W-1:0]);
        resp       = word_i[SECRET_W+SEL_W-1:SEL_W];
        ref_secret = (sel == SEL_TZ) ? tz_secret_i : nw_secret_i;
    end

    // Each lane reports whether any of its bits differ.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_diff[g] = |(resp[g*LANE_W +: LANE_W] ^ ref_secret[g*LANE_W +: LANE_W]);
    end

    // Combine the lanes and qualify the result with selector and fuse validity.
    always_comb begin
        equal      = ~|lane_diff;
        grant_nw_o = equal && (sel == SEL_NW) && nw_fuse_ok_i;
        grant_tz_o = equal && (sel == SEL_TZ) && tz_fuse_ok_i;
    end
endmodule

// File: rtl/dbgu_gate.sv
// Module dbgu_gate: holds the pending-challenge flag, the failure count with
// its lockout, the sticky debug enables, and the one-cycle verdict pulses.
// Assumes submit has priority over request in the same cycle.
module dbgu_gate #(
    parameter int MAX_FAIL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic submit_i,
    input  logic grant_nw_i,
    input  logic grant_tz_i,
    output logic pass_o,
    output logic fail_o,
    output logic locked_o,
    output logic nw_en_o,
    output logic tz_en_o
);
    localparam int CNT_W = $clog2(MAX_FAIL + 1);

    logic             chal_q;
    logic [CNT_W-1:0] fail_cnt_q;
    logic             pass_q, fail_q, nw_en_q, tz_en_q;
    logic             locked;

    // The lockout holds once the count reaches the limit.
    assign locked = (fail_cnt_q >= CNT_W'(MAX_FAIL));

    // Judge each submit, track failures and latch the granted enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chal_q     <= 1'b0;
            fail_cnt_q <= '0;
            pass_q     <= 1'b0;
            fail_q     <= 1'b0;
            nw_en_q    <= 1'b0;
            tz_en_q    <= 1'b0;
        end else begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            if (submit_i) begin
                chal_q <= 1'b0;
                if (locked) begin
                    fail_q <= 1'b1;
                end else if (chal_q && (grant_nw_i || grant_tz_i)) begin
                    pass_q     <= 1'b1;
                    fail_cnt_q <= '0;
                    nw_en_q    <= 1'b1;
                    if (grant_tz_i) tz_en_q <= 1'b1;
                end else begin
                    fail_q     <= 1'b1;
                    fail_cnt_q <= fail_cnt_q + 1'b1;
                end
            end else if (req_i) begin
                chal_q <= 1'b1;
            end
        end
    end

    assign pass_o   = pass_q;
    assign fail_o   = fail_q;
    assign locked_o = locked;
    assign nw_en_o  = nw_en_q;
    assign tz_en_o  = tz_en_q;

    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));                                    // R10
    AST_VERDICT_FROM_SUBMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || fail_o) |-> $past(submit_i));                 // R10
    AST_NO_CHAL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (submit_i && !chal_q) |=> (fail_o && !pass_o));          // R7
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> (locked_o && !pass_o));                     // R8
    AST_NW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        nw_en_o |=> nw_en_o);                                    // R9
    AST_TZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tz_en_o |=> tz_en_o);                                    // R9
    AST_TZ_IMPLIES_NW: assert property (@(posedge clk) disable iff (!rst_n)
        tz_en_o |-> nw_en_o);                                    // R5
endmodule

// File: rtl/dbg_challenge_unlock.sv
// Module dbg_challenge_unlock: top of the challenge-response debug unlock.
// Connects the shift register, the secret comparator and the verdict logic.
// Assumes the fuse inputs are static after reset. Command priority is
// submit, then request, then shift.
module dbg_challenge_unlock
    import dbgu_pkg::*;
#(
    parameter int MAX_FAIL = 3,
    parameter int LANE_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                submit_i,
    input  logic                shift_i,
    input  logic                tdi_i,
    output logic                tdo_o,
    input  logic [ID_W-1:0]     uid_i,
    input  logic [SECRET_W-1:0] nw_secret_i,
    input  logic [SECRET_W-1:0] tz_secret_i,
    input  logic                nw_fuse_ok_i,
    input  logic                tz_fuse_ok_i,
    output logic                pass_o,
    output logic                fail_o,
    output logic                locked_o,
    output logic                nw_dbg_en_o,
    output logic                tz_dbg_en_o
);
    logic              load, shift;
    logic [WORD_W-1:0] word;
    logic              grant_nw, grant_tz;

    // Apply the command priority before the shift register sees the strobes.
    assign load  = req_i && !submit_i;
    assign shift = shift_i && !req_i && !submit_i;

    dbgu_capture #(.WORD_W(WORD_W), .ID_W(ID_W)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .tdi_i   (tdi_i),
        .uid_i   (uid_i),
        .word_o  (word),
        .tdo_o   (tdo_o)
    );

    dbgu_compare #(.SECRET_W(SECRET_W), .LANE_W(LANE_W)) i_compare (
        .word_i       (word),
        .nw_secret_i  (nw_secret_i),
        .tz_secret_i  (tz_secret_i),
        .nw_fuse_ok_i (nw_fuse_ok_i),
        .tz_fuse_ok_i (tz_fuse_ok_i),
        .grant_nw_o   (grant_nw),
        .grant_tz_o   (grant_tz)
    );

    dbgu_gate #(.MAX_FAIL(MAX_FAIL)) i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .submit_i   (submit_i),
        .grant_nw_i (grant_nw),
        .grant_tz_i (grant_tz),
        .pass_o     (pass_o),
        .fail_o     (fail_o),
        .locked_o   (locked_o),
        .nw_en_o    (nw_dbg_en_o),
        .tz_en_o    (tz_dbg_en_o)
    );
endmodule

// File: tb/test_dbg_challenge_unlock.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model (a bit queue and integer counters)
// is checked against the design on every falling edge.
module test_dbg_challenge_unlock;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_i = 1'b0, submit_i = 1'b0, shift_i = 1'b0, tdi_i = 1'b0;
    logic [63:0]  uid_i = 64'hC3A5_0F1E_9B27_6D48;
    logic [127:0] nw_secret_i = 128'h1357_9BDF_2468_ACE0_F0E1_D2C3_B4A5_9687;
    logic [127:0] tz_secret_i = 128'h8E3C_55AA_0123_4567_89AB_CDEF_7F00_FF11;
    logic         nw_fuse_ok_i = 1'b1, tz_fuse_ok_i = 1'b1;
    logic         tdo_o, pass_o, fail_o, locked_o, nw_dbg_en_o, tz_dbg_en_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference model state.
    bit q[$];
    bit m_chal, m_pass, m_fail, m_nw, m_tz;
    int m_fails;

    always #10 clk = ~clk;

    dbg_challenge_unlock i_dbg_challenge_unlock (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .submit_i(submit_i),
        .shift_i(shift_i), .tdi_i(tdi_i), .tdo_o(tdo_o), .uid_i(uid_i),
        .nw_secret_i(nw_secret_i), .tz_secret_i(tz_secret_i),
        .nw_fuse_ok_i(nw_fuse_ok_i), .tz_fuse_ok_i(tz_fuse_ok_i),
        .pass_o(pass_o), .fail_o(fail_o), .locked_o(locked_o),
        .nw_dbg_en_o(nw_dbg_en_o), .tz_dbg_en_o(tz_dbg_en_o));

    // Model: mirror the requirements at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            for (int i = 0; i < 130; i++) q.push_back(1'b0);
            m_chal = 0; m_pass = 0; m_fail = 0; m_nw = 0; m_tz = 0; m_fails = 0;
        end else begin
            m_pass = 0; m_fail = 0;
            if (submit_i) begin
                logic [129:0] w;
                logic ok;
                for (int i = 0; i < 130; i++) w[i] = q[i];
                ok = (w[1:0] == 2'b01 && nw_fuse_ok_i && w[129:2] == nw_secret_i) ||
                     (w[1:0] == 2'b10 && tz_fuse_ok_i && w[129:2] == tz_secret_i);
                if (m_fails >= 3) m_fail = 1;
                else if (m_chal && ok) begin
                    m_pass = 1; m_fails = 0; m_nw = 1;
                    if (w[1:0] == 2'b10) m_tz = 1;
                end else begin
                    m_fail = 1; m_fails++;
                end
                m_chal = 0;
            end else if (req_i) begin
                q.delete();
                for (int i = 0; i < 64; i++) q.push_back(uid_i[i]);
                for (int i = 64; i < 130; i++) q.push_back(1'b0);
                m_chal = 1;
            end else if (shift_i) begin
                void'(q.pop_front());
                q.push_back(tdi_i);
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 tdo", tdo_o, q[0]);
            chk("R4 pass", pass_o, m_pass);
            chk("R6 fail", fail_o, m_fail);
            chk("R8 locked", locked_o, m_fails >= 3);
            chk("R9 nw_en", nw_dbg_en_o, m_nw);
            chk("R5 tz_en", tz_dbg_en_o, m_tz);
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic do_req();
        @(negedge clk); req_i = 1;
        @(negedge clk); req_i = 0;
    endtask

    task automatic shift_word(input logic [129:0] w);
        for (int i = 0; i < 130; i++) begin
            @(negedge clk); shift_i = 1; tdi_i = w[i];
        end
        @(negedge clk); shift_i = 0; tdi_i = 0;
    endtask

    // Submit, then check the verdict in the cycle after the edge.
    task automatic submit_expect(input string tag, input logic exp_pass);
        @(negedge clk); submit_i = 1;
        @(negedge clk); submit_i = 0;
        chk({tag, " verdict pass"}, pass_o, exp_pass);
        chk({tag, " verdict fail"}, fail_o, !exp_pass);
    endtask

    task automatic attempt(input string tag, input logic [129:0] w, input logic exp_pass);
        do_req();
        shift_word(w);
        submit_expect(tag, exp_pass);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [129:0] nw_w, tz_w;
        nw_w = {nw_secret_i, 2'b01};
        tz_w = {tz_secret_i, 2'b10};
        do_reset();
        // R1: reset state at the ports.
        chk("R1 tdo", tdo_o, 0); chk("R1 pass", pass_o, 0); chk("R1 fail", fail_o, 0);
        chk("R1 locked", locked_o, 0); chk("R1 nw_en", nw_dbg_en_o, 0);
        chk("R1 tz_en", tz_dbg_en_o, 0);
        // R7: submit with no challenge.
        submit_expect("R7 no challenge", 0);
        // R2, R3, R4: normal-world unlock; the challenge bits are observed on tdo.
        attempt("R4 nw unlock", nw_w, 1);
        chk("R4 nw_en", nw_dbg_en_o, 1); chk("R4 tz_en", tz_dbg_en_o, 0);
        // R7: a second submit reuses the spent challenge.
        submit_expect("R7 reuse", 0);
        // R9: enable stays set after that failure.
        chk("R9 nw sticky", nw_dbg_en_o, 1);

        // R5: secure-world unlock sets both enables.
        do_reset();
        attempt("R5 tz unlock", tz_w, 1);
        chk("R5 tz_en", tz_dbg_en_o, 1); chk("R5 nw_en", nw_dbg_en_o, 1);

        // R6: secure secret with the fuse-valid flag low.
        @(negedge clk); rst_n = 0; tz_fuse_ok_i = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        attempt("R6 tz fuse invalid", tz_w, 0);
        chk("R6 no tz_en", tz_dbg_en_o, 0);
        @(negedge clk); rst_n = 0; tz_fuse_ok_i = 1;
        @(negedge clk); @(negedge clk); rst_n = 1;
        // R6: undefined selectors fail; R8: a pass clears the count.
        attempt("R6 sel 00", {nw_secret_i, 2'b00}, 0);
        attempt("R6 sel 11", {nw_secret_i, 2'b11}, 0);
        attempt("R8 pass clears count", nw_w, 1);
        attempt("R6 wrong sel for secret", {nw_secret_i, 2'b10}, 0);
        chk("R8 not locked", locked_o, 0);

        // R11: single-bit mismatches at either end of the response.
        do_reset();
        attempt("R11 bit0 flip", nw_w ^ (130'd1 << 2), 0);
        attempt("R11 bit127 flip", nw_w ^ (130'd1 << 129), 0);
        attempt("R11 tz bit0 flip", tz_w ^ (130'd1 << 2), 0);
        // R8: three failures lock; a correct answer is then refused.
        chk("R8 locked", locked_o, 1);
        attempt("R8 refused when locked", nw_w, 0);
        chk("R8 no grant", nw_dbg_en_o, 0);
        do_reset();
        chk("R8 lock cleared by reset", locked_o, 0);

        // R12: a request coinciding with a submit is ignored.
        @(negedge clk); req_i = 1; submit_i = 1;
        @(negedge clk); req_i = 0; submit_i = 0;
        chk("R12 fail on overlap", fail_o, 1);
        submit_expect("R12 request ignored", 0);
        // R10: no verdict without a submit.
        do_req();
        @(negedge clk);
        chk("R10 idle pass", pass_o, 0); chk("R10 idle fail", fail_o, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule